// File: doc/BRIEF.md
# ISA I/O Window Address Translator

This block bridges a 32-bit CPU load/store window to an ISA-style I/O bus. The CPU issues byte, halfword or word accesses; any access that lands in the 8 MB I/O aperture starting at 0x80000000 is turned into exactly one I/O bus request. The request carries a 16-bit port number, the access size and the write data. The CPU side is big-endian, so multi-byte data is byte-reversed in both directions.

Two ways of folding the window offset into a port number are offered, chosen by a map-select input. The contiguous fold keeps the low 16 address bits. The sparse fold keeps the low 5 bits and packs page-number bits 12 and up down to bit 5. This lets each 32-byte port group sit in its own 4 KB page.

The block also answers one fixed interrupt-acknowledge address, 0xBFFFFFF0. A read there returns the vector offered by an external interrupt controller and pulses a take strobe to that controller. Every other access gets a quiet completion with zero read data and no bus activity.

Top module: `isa_io_bridge`

## Requirements
- R1: An access whose address lies in 0x80000000..0x807FFFFF produces exactly one I/O request. Any other address produces none, and the CPU gets `cpu_ready` in the cycle after acceptance with `cpu_rdata` = 0, except for the acknowledge read of R6.
- R2: With `map_sparse` = 0, `io_addr` equals the CPU address ANDed with 0xFFFF.
- R3: With `map_sparse` = 1, `io_addr` equals ((addr AND 0x1F) OR ((addr AND 0x07FFF000) >> 7)), truncated to 16 bits.
- R4: Size codes are 0 = byte, 1 = halfword, 2 = word, and 3 is treated as word. `io_size` repeats the CPU code. `io_wdata` is laid out as follows:
  - byte: CPU byte 0 in lane 0;
  - halfword: CPU bytes 1,0 in lanes 0,1;
  - word: CPU bytes 3..0 in lanes 0..3;
  - lanes above the access size are 0.
- R5: Read data from `io_rdata` goes through the same lane reversal and zeroing as R4, using the size of the access, before it appears on `cpu_rdata`.
- R6: A read at exactly 0xBFFFFFF0 pulses `iack_take` in the cycle it is accepted and issues no I/O request. It returns `iack_vector`, zero-extended to 32 bits and lane-reversed by size as in R5: byte in lane 0, halfword in lane 1, word in lane 3.
- R7: Reads at 0xBFFFFFF1..0xBFFFFFF3 return 0. Writes anywhere in 0xBFFFFFF0..0xBFFFFFF3 are ignored. Neither case pulses `iack_take` or issues an I/O request.
- R8: `map_sparse` is sampled when an access is accepted. Changing it while a request waits for `io_ready` leaves `io_addr` unchanged.
- R9: `io_valid` stays high with stable address, size and data until `io_ready`. `cpu_ready` is a one-cycle pulse in the cycle after the I/O handshake.
- R10: After reset `io_valid`, `cpu_ready` and `iack_take` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_sparse | input | 1 | 0 selects contiguous fold, 1 sparse fold |
| cpu_valid | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_ready | output | 1 | Access complete, read data valid |
| cpu_addr | input | 32 | CPU physical address |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| cpu_wdata | input | 32 | CPU write data, big-endian lanes |
| cpu_rdata | output | 32 | Read data returned to the CPU |
| io_valid | output | 1 | I/O bus request |
| io_ready | input | 1 | I/O bus acknowledge |
| io_addr | output | 16 | Translated port number |
| io_write | output | 1 | I/O direction |
| io_size | output | 2 | I/O access size code |
| io_wdata | output | 32 | Lane-reversed write data |
| io_rdata | input | 32 | Read data from the I/O bus |
| iack_vector | input | 8 | Vector offered by the interrupt controller |
| iack_take | output | 1 | Pulse when the vector is consumed |

## Verification
Two things can coincide with a waiting I/O request: a change of `map_sparse` and the arrival of `io_ready`. The bench flips the map select on every cycle a request is pending. It also varies the acknowledge delay from zero, where `io_ready` is already high when the request first appears, up to several cycles. It then checks that the port number stays at the value computed from the map in force at acceptance. It also checks that `cpu_ready` arrives exactly one cycle after the handshake, with the reversed read data.

// File: rtl/isa_bridge_pkg.sv
package isa_bridge_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } xfer_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RESP = 2'd2
   } bridge_state_e;

   // number of active byte lanes for a size code
   function automatic int size_bytes(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: return 1;
         SZ_HALF: return 2;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/isa_lane_swap.sv
module isa_lane_swap #(
   parameter int DATA_BYTES = 4
) (
   input  logic [1:0]              size,
   input  logic [8*DATA_BYTES-1:0] din,
   output logic [8*DATA_BYTES-1:0] dout
);
   import isa_bridge_pkg::*;

   initial begin
      assert (DATA_BYTES >= 4) else $error("isa_lane_swap: DATA_BYTES must be at least 4");
   end

   int active;
   always_comb active = size_bytes(size);

   for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
      logic [7:0] lane_v;
      always_comb begin
         lane_v = 8'h00;
         for (int s = 0; s < DATA_BYTES; s++) begin
            if ((i < active) && (s == active - 1 - i)) lane_v = din[8*s +: 8];
         end
      end
      assign dout[8*i +: 8] = lane_v;
   end

endmodule

// File: rtl/isa_addr_fold.sv
module isa_addr_fold #(
   parameter int ADDR_W     = 32,
   parameter int PORT_W     = 16,
   parameter bit SPARSE_EN  = 1'b1,
   parameter int LOW_BITS   = 5,
   parameter int PAGE_SHIFT = 12,
   parameter int PAGE_TOP   = 26
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              map_sparse,
   output logic [PORT_W-1:0] port
);
   localparam int DROP = PAGE_SHIFT - LOW_BITS;

   initial begin
      assert (PORT_W <= ADDR_W) else $error("isa_addr_fold: PORT_W exceeds ADDR_W");
      assert (PAGE_SHIFT > LOW_BITS) else $error("isa_addr_fold: page field overlaps low field");
      assert (PAGE_TOP < ADDR_W - 1) else $error("isa_addr_fold: PAGE_TOP out of range");
   end

   if (SPARSE_EN) begin : g_sparse
      localparam logic [ADDR_W-1:0] LOW_MASK  = (ADDR_W'(1) << LOW_BITS) - ADDR_W'(1);
      localparam logic [ADDR_W-1:0] PAGE_MASK =
         ((ADDR_W'(1) << (PAGE_TOP + 1)) - ADDR_W'(1)) & ~((ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1));
      logic [ADDR_W-1:0] packed_v;
      always_comb begin
         packed_v = ((addr & PAGE_MASK) >> DROP) | (addr & LOW_MASK);
         port     = map_sparse ? packed_v[PORT_W-1:0] : addr[PORT_W-1:0];
      end
   end else begin : g_contig
      logic [ADDR_W-1:0] addr_all;
      always_comb begin
         addr_all = addr | {ADDR_W{map_sparse & 1'b0}};
         port     = addr_all[PORT_W-1:0];
      end
   end

endmodule

// File: rtl/isa_window_decode.sv
module isa_window_decode #(
   parameter int                ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h8000_0000,
   parameter int                WIN_LOG2  = 23,
   parameter logic [ADDR_W-1:0] IACK_ADDR = 32'hBFFF_FFF0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              in_window,
   output logic              iack_exact
);
   initial begin
      assert (WIN_LOG2 < ADDR_W) else $error("isa_window_decode: window wider than address");
      assert ((WIN_BASE & ((ADDR_W'(1) << WIN_LOG2) - ADDR_W'(1))) == '0)
         else $error("isa_window_decode: window base not aligned to its span");
   end

   always_comb begin
      in_window  = (addr >> WIN_LOG2) == (WIN_BASE >> WIN_LOG2);
      iack_exact = (addr == IACK_ADDR);
   end

endmodule

// File: rtl/isa_io_bridge.sv
module isa_io_bridge #(
   parameter int                ADDR_W     = 32,
   parameter int                DATA_BYTES = 4,
   parameter int                PORT_W     = 16,
   parameter int                VEC_W      = 8,
   parameter bit                SPARSE_EN  = 1'b1,
   parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h8000_0000,
   parameter int                WIN_LOG2   = 23,
   parameter logic [ADDR_W-1:0] IACK_ADDR  = 32'hBFFF_FFF0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    map_sparse,
   input  logic                    cpu_valid,
   output logic                    cpu_ready,
   input  logic [ADDR_W-1:0]       cpu_addr,
   input  logic                    cpu_write,
   input  logic [1:0]              cpu_size,
   input  logic [8*DATA_BYTES-1:0] cpu_wdata,
   output logic [8*DATA_BYTES-1:0] cpu_rdata,
   output logic                    io_valid,
   input  logic                    io_ready,
   output logic [PORT_W-1:0]       io_addr,
   output logic                    io_write,
   output logic [1:0]              io_size,
   output logic [8*DATA_BYTES-1:0] io_wdata,
   input  logic [8*DATA_BYTES-1:0] io_rdata,
   input  logic [VEC_W-1:0]        iack_vector,
   output logic                    iack_take
);
   import isa_bridge_pkg::*;

   localparam int DATA_W = 8 * DATA_BYTES;

   initial begin
      assert (VEC_W <= DATA_W) else $error("isa_io_bridge: vector wider than data path");
   end

   bridge_state_e       state_q;
   logic [PORT_W-1:0]   port_q;
   logic                write_q;
   logic [1:0]          size_q;
   logic [DATA_W-1:0]   wdata_q;
   logic [DATA_W-1:0]   rdata_q;

   logic                hit_win, hit_iack;
   logic [PORT_W-1:0]   port_d;
   logic [DATA_W-1:0]   wswap, rswap, vswap;
   logic                accept;

   isa_window_decode #(
      .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2), .IACK_ADDR(IACK_ADDR)
   ) u_dec (
      .addr(cpu_addr), .in_window(hit_win), .iack_exact(hit_iack)
   );

   isa_addr_fold #(
      .ADDR_W(ADDR_W), .PORT_W(PORT_W), .SPARSE_EN(SPARSE_EN)
   ) u_fold (
      .addr(cpu_addr), .map_sparse(map_sparse), .port(port_d)
   );

   isa_lane_swap #(.DATA_BYTES(DATA_BYTES)) u_wswap (
      .size(cpu_size), .din(cpu_wdata), .dout(wswap)
   );

   isa_lane_swap #(.DATA_BYTES(DATA_BYTES)) u_rswap (
      .size(size_q), .din(io_rdata), .dout(rswap)
   );

   isa_lane_swap #(.DATA_BYTES(DATA_BYTES)) u_vswap (
      .size(cpu_size), .din(DATA_W'(iack_vector)), .dout(vswap)
   );

   always_comb begin
      accept    = (state_q == ST_IDLE) && cpu_valid;
      iack_take = accept && hit_iack && !cpu_write;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         port_q  <= '0;
         write_q <= 1'b0;
         size_q  <= 2'd0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (cpu_valid) begin
                  if (hit_win) begin
                     port_q  <= port_d;
                     write_q <= cpu_write;
                     size_q  <= cpu_size;
                     wdata_q <= cpu_write ? wswap : '0;
                     rdata_q <= '0;
                     state_q <= ST_WAIT;
                  end else begin
                     rdata_q <= (hit_iack && !cpu_write) ? vswap : '0;
                     state_q <= ST_RESP;
                  end
               end
            end
            ST_WAIT: begin
               if (io_ready) begin
                  rdata_q <= write_q ? '0 : rswap;
                  state_q <= ST_RESP;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      io_valid  = (state_q == ST_WAIT);
      cpu_ready = (state_q == ST_RESP);
      io_addr   = port_q;
      io_write  = write_q;
      io_size   = size_q;
      io_wdata  = wdata_q;
      cpu_rdata = rdata_q;
   end

endmodule

// File: rtl/isa_io_bridge_chk.sv
module isa_io_bridge_chk #(
   parameter int PORT_W = 16,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_ready,
   input logic              io_valid,
   input logic              io_ready,
   input logic [PORT_W-1:0] io_addr,
   input logic [1:0]        io_size,
   input logic [DATA_W-1:0] io_wdata,
   input logic              iack_take
);
   // R9: request held steady until acknowledged
   assert_hold_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
      io_valid && !io_ready |=> io_valid && $stable(io_size) && $stable(io_wdata));

   // R8: port number frozen while waiting, whatever the map select does
   assert_port_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      io_valid && !io_ready |=> $stable(io_addr));

   // R9: completion one cycle after the I/O handshake
   assert_resp_after_io_R9: assert property (@(posedge clk) disable iff (!rst_n)
      io_valid && io_ready |=> cpu_ready && !io_valid);

   // R9: completion is a single-cycle pulse
   assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready);

   // R6: acknowledge read completes locally next cycle
   assert_iack_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
      iack_take |=> cpu_ready && !io_valid);

   // R1: bus request and completion never overlap
   assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({io_valid, cpu_ready}));

endmodule

bind isa_io_bridge isa_io_bridge_chk #(.PORT_W(PORT_W), .DATA_W(8*DATA_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .io_valid(io_valid),
   .io_ready(io_ready), .io_addr(io_addr), .io_size(io_size),
   .io_wdata(io_wdata), .iack_take(iack_take)
);

// File: tb/tb_isa_io_bridge.sv
module tb_isa_io_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        map_sparse = 1'b0;
   logic        cpu_valid = 1'b0;
   logic        cpu_ready;
   logic [31:0] cpu_addr = '0;
   logic        cpu_write = 1'b0;
   logic [1:0]  cpu_size = 2'd0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        io_valid;
   logic        io_ready = 1'b0;
   logic [15:0] io_addr;
   logic        io_write;
   logic [1:0]  io_size;
   logic [31:0] io_wdata;
   logic [31:0] io_rdata = '0;
   logic [7:0]  iack_vector = '0;
   logic        iack_take;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   isa_io_bridge dut (
      .clk(clk), .rst_n(rst_n), .map_sparse(map_sparse),
      .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_addr(cpu_addr),
      .cpu_write(cpu_write), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .io_valid(io_valid), .io_ready(io_ready),
      .io_addr(io_addr), .io_write(io_write), .io_size(io_size),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .iack_vector(iack_vector),
      .iack_take(iack_take)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] fold(input logic [31:0] a, input bit sparse);
      logic [31:0] t;
      if (sparse) t = (a & 32'h0000_001F) | ((a & 32'h07FF_F000) >> 7);
      else        t = a & 32'h0000_FFFF;
      return t[15:0];
   endfunction

   function automatic logic [31:0] lanes(input logic [31:0] d, input logic [1:0] sz);
      case (sz)
         2'd0:    return {24'h0, d[7:0]};
         2'd1:    return {16'h0, d[7:0], d[15:8]};
         default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
      endcase
   endfunction

   // one CPU access with an I/O responder that waits wait_n cycles
   task automatic access(input logic [31:0] a, input bit wr, input logic [1:0] sz,
                         input logic [31:0] wd, input bit sparse, input int wait_n,
                         input logic [31:0] rdv,
                         output bit saw_io, output logic [15:0] got_addr,
                         output logic [31:0] got_wdata, output logic [1:0] got_size,
                         output bit got_write, output logic [31:0] got_rdata,
                         output bit got_take, output int io_beats);
      int n;
      int guard;
      saw_io = 0; got_addr = '0; got_wdata = '0; got_size = '0; got_write = 0;
      io_beats = 0; n = 0; guard = 0;
      @(negedge clk);
      cpu_valid = 1'b1; cpu_addr = a; cpu_write = wr; cpu_size = sz;
      cpu_wdata = wd; map_sparse = sparse; io_ready = 1'b0; io_rdata = rdv;
      #1 got_take = iack_take;
      @(posedge clk);
      @(negedge clk);
      while (!cpu_ready && guard < 50) begin
         if (io_valid) begin
            if (!saw_io) begin
               got_addr = io_addr; got_wdata = io_wdata;
               got_size = io_size; got_write = io_write;
            end else begin
               check(io_addr == got_addr, "R8", "port held under map change",
                     {16'h0, io_addr}, {16'h0, got_addr});
            end
            saw_io = 1;
            map_sparse = ~sparse;
            if (n >= wait_n) begin
               io_ready = 1'b1;
               io_beats++;
            end
            n++;
         end
         @(posedge clk);
         @(negedge clk);
         io_ready = 1'b0;
         guard++;
      end
      check(cpu_ready == 1'b1, "R9", "completion seen", {31'h0, cpu_ready}, 32'h1);
      check(!io_valid, "R9", "bus idle at completion", {31'h0, io_valid}, 32'h0);
      got_rdata = cpu_rdata;
      @(posedge clk);
      @(negedge clk);
      cpu_valid = 1'b0;
      map_sparse = sparse;
      check(!cpu_ready, "R9", "completion single cycle", {31'h0, cpu_ready}, 32'h0);
   endtask

   initial begin : watchdog
      while (cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      bit          s_io, s_wr, s_take;
      logic [15:0] s_addr;
      logic [31:0] s_wd, s_rd;
      logic [1:0]  s_sz;
      int          beats;
      logic [31:0] a, wd, rdv;

      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!io_valid && !cpu_ready && !iack_take, "R10", "quiet during reset",
            {29'h0, io_valid, cpu_ready, iack_take}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!io_valid && !cpu_ready && !iack_take, "R10", "quiet after reset",
            {29'h0, io_valid, cpu_ready, iack_take}, 32'h0);

      // window sweep: sizes x maps x addresses x direction
      for (int sz = 0; sz < 4; sz++) begin
         for (int mp = 0; mp < 2; mp++) begin
            for (int i = 0; i < 18; i++) begin
               if (i == 0)      a = 32'h8000_0000;
               else if (i == 1) a = 32'h807F_FFFF;
               else             a = 32'h8000_0000 + ((i * 32'h0005_1E37 + sz * 32'h0001_0203) & 32'h007F_FFFF);
               wd  = 32'hA1B2_C3D4 ^ (i * 32'h0101_0101) ^ (sz * 32'h1357_9BDF);
               rdv = 32'h5E6F_7081 + i * 32'h0F1E_2D3C + mp;
               access(a, i[0], 2'(sz), wd, mp[0], (i + sz) % 4, rdv,
                      s_io, s_addr, s_wd, s_sz, s_wr, s_rd, s_take, beats);
               check(s_io && beats == 1, "R1", "one request in window", {31'h0, s_io}, 32'h1);
               if (mp == 0)
                  check(s_addr == fold(a, 1'b0), "R2", "contiguous port",
                        {16'h0, s_addr}, {16'h0, fold(a, 1'b0)});
               else
                  check(s_addr == fold(a, 1'b1), "R3", "sparse port",
                        {16'h0, s_addr}, {16'h0, fold(a, 1'b1)});
               check(s_sz == 2'(sz) && s_wr == i[0], "R4", "size and direction",
                     {29'h0, s_wr, s_sz}, {29'h0, i[0], 2'(sz)});
               if (i[0]) begin
                  check(s_wd == lanes(wd, 2'(sz)), "R4", "write lane order", s_wd, lanes(wd, 2'(sz)));
               end else begin
                  check(s_rd == lanes(rdv, 2'(sz)), "R5", "read lane order", s_rd, lanes(rdv, 2'(sz)));
               end
               check(!s_take, "R6", "no take strobe for I/O", {31'h0, s_take}, 32'h0);
            end
         end
      end

      // outside the window: no request, zero data
      for (int k = 0; k < 5; k++) begin
         case (k)
            0: a = 32'h7FFF_FFFF;
            1: a = 32'h8080_0000;
            2: a = 32'h0000_0398;
            3: a = 32'hBFFF_FFF4;
            default: a = 32'hFFFF_FFFF;
         endcase
         for (int wr = 0; wr < 2; wr++) begin
            access(a, wr[0], 2'd2, 32'h1234_5678, k[0], 0, 32'hDEAD_BEEF,
                   s_io, s_addr, s_wd, s_sz, s_wr, s_rd, s_take, beats);
            check(!s_io, "R1", "no request outside window", {31'h0, s_io}, 32'h0);
            check(s_rd == 32'h0, "R1", "zero data outside window", s_rd, 32'h0);
         end
      end

      // acknowledge location: offsets x sizes x direction
      for (int off = 0; off < 4; off++) begin
         for (int sz = 0; sz < 4; sz++) begin
            for (int wr = 0; wr < 2; wr++) begin
               iack_vector = 8'h20 + 8'(off * 16 + sz * 4 + wr);
               access(32'hBFFF_FFF0 + off, wr[0], 2'(sz), 32'hCAFE_F00D, 1'b0, 0, 32'h1111_2222,
                      s_io, s_addr, s_wd, s_sz, s_wr, s_rd, s_take, beats);
               if (off == 0 && wr == 0) begin
                  check(s_take, "R6", "take strobe on vector read", {31'h0, s_take}, 32'h1);
                  check(s_rd == lanes({24'h0, iack_vector}, 2'(sz)), "R6", "vector lane order",
                        s_rd, lanes({24'h0, iack_vector}, 2'(sz)));
                  check(!s_io, "R6", "no bus request for vector", {31'h0, s_io}, 32'h0);
               end else begin
                  check(!s_take, "R7", "no take strobe", {31'h0, s_take}, 32'h0);
                  check(!s_io, "R7", "no bus request", {31'h0, s_io}, 32'h0);
                  check(s_rd == 32'h0, "R7", "zero data", s_rd, 32'h0);
               end
            end
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule